// File: doc/BRIEF.md
# Doorbell Mailbox Command Sequencer

This block sits on the host side of a register mailbox that connects the host to a service engine. Callers post commands into a small request queue. The block takes them one at a time, from the head of the queue. For each command it builds a header word, stamps a sequence number into it, presents the four command words on the mailbox write port, and rings the engine doorbell. It always asks the engine for an acknowledge. Only one command is in the mailbox at any time.

The engine reports back through a level-sensitive host doorbell. The block services one doorbell cause per cycle in a fixed priority order. It clears each cause it handles through an AND-mask write port before it looks at the next one.

- An acknowledge finishes a command that expects no reply.
- A response finishes a command once its sequence number has been checked.
- An engine-reset indication drops the in-flight command back to the queue so that it is sent again.
- Passthrough and timer-expiry causes turn into one-cycle pulses.
- A programmable cycle limit bounds how long any command may stay in flight.

Every command ends with exactly one completion record, which carries a code, a 16-bit status and the sequence number.

Top module: `mbx_cmd_seq`

## Requirements
- R1: The header word `cmd_w0` places subclass in bits 7:0, class in bits 15:8, sequence number in bits 31:16 and control flags in bits 47:32, with bits 63:48 zero. `cmd_w1`..`cmd_w3` carry the three request data words unchanged.
- R2: Flag bit 8 (acknowledge request, `cmd_w0` bit 40) is always set in the sent header. All other flag bits are passed through as given; flag bit 9 marks a command that expects a response.
- R3: Each accepted request takes a sequence number. The first after reset is 1 and each later one is one higher. After the value 2^SEQ_W−2 the next value is 1, so 0 and the all-ones value are never used.
- R4: While a command is in flight (rung and not yet completed), no further command words are written and the doorbell is not rung.
- R5: An acknowledge (doorbell bit 1) for a command without flag bit 9 completes it with code 0 (done) and status 0. For a command with flag bit 9 it produces no completion and the block waits for the response.
- R6: A response (doorbell bit 2) completes the in-flight command with code 0. The status is `rsp_hdr[63:48]` when `rsp_hdr[31:16]` equals the command's sequence number, and STAT_SEQ_ERR otherwise.
- R7: Doorbell causes are served one per cycle in this order: bit 0 reset, bit 1 acknowledge, bit 2 response, bit 3 passthrough, bit 4 timer. Each served known cause is cleared with `db_and_we` and `db_and_val` = all ones except that bit.
- R8: When bit 0 is set, all doorbell bits are cleared (`db_and_val` = 0) and the mailbox returns to idle without a completion. The in-flight command is then sent again with the same sequence number.
- R9: Serving bit 3 or bit 4 produces a single-cycle pulse on `pass_pulse` or `timer_pulse` respectively.
- R10: When only bits above bit 4 are set, they are cleared together with `db_and_val` holding ones in bits 4:0 only, with no other effect.
- R11: A command that gets no completing doorbell event completes with code 2 and status STAT_GEN_ERR. `cpl_valid` is high exactly `tmo_limit`+2 cycles after the cycle in which `eng_ring` was high.
- R12: If `cmd_err` is high while `cmd_we` is high, the doorbell is not rung and the command completes with code 1 and status STAT_GEN_ERR. After MAX_FAILS consecutive failures, no command is written until a doorbell cause is served.
- R13: A response with no command in flight is cleared and produces no completion.
- R14: `req_ready` is high while the queue holds fewer than DEPTH commands, counting the in-flight one, and low when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_class | input | 8 | Command class |
| req_sub | input | 8 | Command subclass |
| req_flags | input | 16 | Caller control flags |
| req_d1 | input | 64 | Command data word 1 |
| req_d2 | input | 64 | Command data word 2 |
| req_d3 | input | 64 | Command data word 3 |
| cmd_we | output | 1 | Command words are being written |
| cmd_w0 | output | 64 | Header word |
| cmd_w1 | output | 64 | Data word 1 |
| cmd_w2 | output | 64 | Data word 2 |
| cmd_w3 | output | 64 | Data word 3 |
| cmd_err | input | 1 | The current command write failed |
| eng_ring | output | 1 | Sets the message-waiting bit in the engine doorbell |
| host_db | input | DB_W | Host doorbell register value |
| db_and_we | output | 1 | AND-mask write to the host doorbell |
| db_and_val | output | DB_W | Mask ANDed into the host doorbell |
| rsp_hdr | input | 64 | Response header word |
| tmo_limit | input | TMO_W | Timeout limit in cycles |
| cpl_valid | output | 1 | Completion record valid |
| cpl_code | output | 2 | 0 done, 1 send error, 2 timeout |
| cpl_status | output | 16 | Primary status of the completed command |
| cpl_seq | output | 16 | Sequence number of the completed command |
| pass_pulse | output | 1 | Passthrough cause served |
| timer_pulse | output | 1 | Timer-expiry cause served |

## Verification
The bench targets the following corner cases.

- **All causes at once.** It sets acknowledge, response, passthrough, timer and an unknown bit in the same cycle, then checks the order of the clear masks. A picker with the wrong priority, or one that cleared several bits at once, would reorder or merge those writes.
- **Reset together with acknowledge.** It raises the reset bit alongside an acknowledge. A design that let the acknowledge through would complete a command that must instead be resent with the same sequence number.
- **Sequence and timeout boundaries.** It sweeps the sequence counter through its wrap, which exposes an off-by-one that emits 0 or the all-ones value. It measures the exact timeout cycle.
- **Send failures.** It drives three send failures in a row. A design that never stops would keep writing command words, and one that never restarts would hang the queue.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int WORD_W   = 64;
   localparam int DB_RESET = 0;
   localparam int DB_ACK   = 1;
   localparam int DB_RESP  = 2;
   localparam int DB_PASS  = 3;
   localparam int DB_TIMER = 4;
   localparam int DB_KNOWN = 5;

   typedef enum logic [1:0] {
      CPL_DONE = 2'd0,
      CPL_ERR  = 2'd1,
      CPL_TMO  = 2'd2
   } cpl_code_e;

   typedef enum logic [1:0] {
      MB_IDLE  = 2'd0,
      MB_SENT  = 2'd1,
      MB_WRESP = 2'd2
   } mb_state_e;

   typedef enum logic [2:0] {
      EV_NONE, EV_RESET, EV_ACK, EV_RESP, EV_PASS, EV_TIMER, EV_UNKNOWN
   } db_ev_e;

   typedef struct packed {
      logic [7:0]        cls;
      logic [7:0]        sub;
      logic [15:0]       flags;
      logic [15:0]       seq;
      logic [WORD_W-1:0] d1;
      logic [WORD_W-1:0] d2;
      logic [WORD_W-1:0] d3;
   } cmd_ent_t;

endpackage

// File: rtl/mbx_cmd_fifo.sv
module mbx_cmd_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mbx_cmd_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign dout  = mem[rd_ptr];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   a_r14_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/mbx_seq_gen.sv
module mbx_seq_gen #(
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [SEQ_W-1:0] seq
);
   localparam logic [SEQ_W-1:0] WRAP_AT = '1;
   localparam logic [SEQ_W-1:0] FIRST   = SEQ_W'(1);

   generate
      if (SEQ_W < 2 || SEQ_W > 16) begin : g_bad_seq
         $error("mbx_seq_gen: SEQ_W must lie in 2..16");
      end
   endgenerate

   logic [SEQ_W-1:0] nxt;
   assign nxt = seq + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seq <= FIRST;
      else if (advance) seq <= (nxt == WRAP_AT) ? FIRST : nxt;
   end

   a_r3_seq_range: assert property (@(posedge clk) disable iff (!rst_n)
      (seq != '0) && (seq != WRAP_AT));
   a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (seq == $past(seq) + 1'b1) || (seq == FIRST));

endmodule

// File: rtl/mbx_db_pick.sv
module mbx_db_pick
   import mbx_pkg::*;
#(
   parameter int DB_W = 64
) (
   input  logic [DB_W-1:0] bits,
   output db_ev_e          ev,
   output logic [DB_W-1:0] and_val
);
   localparam logic [DB_W-1:0] KEEP_KNOWN = DB_W'({DB_KNOWN{1'b1}});

   generate
      if (DB_W <= DB_KNOWN) begin : g_bad_db
         $error("mbx_db_pick: DB_W must exceed the number of known causes");
      end
   endgenerate

   function automatic logic [DB_W-1:0] drop(input int idx);
      return ~(DB_W'(1) << idx);
   endfunction

   always_comb begin
      ev      = EV_NONE;
      and_val = '1;
      if (bits[DB_RESET]) begin
         ev      = EV_RESET;
         and_val = '0;
      end else if (bits[DB_ACK]) begin
         ev      = EV_ACK;
         and_val = drop(DB_ACK);
      end else if (bits[DB_RESP]) begin
         ev      = EV_RESP;
         and_val = drop(DB_RESP);
      end else if (bits[DB_PASS]) begin
         ev      = EV_PASS;
         and_val = drop(DB_PASS);
      end else if (bits[DB_TIMER]) begin
         ev      = EV_TIMER;
         and_val = drop(DB_TIMER);
      end else if (|bits) begin
         ev      = EV_UNKNOWN;
         and_val = KEEP_KNOWN;
      end
   end

endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
   import mbx_pkg::*;
#(
   parameter int          DEPTH        = 4,
   parameter int          SEQ_W        = 16,
   parameter int          TMO_W        = 24,
   parameter int          DB_W         = 64,
   parameter int          ACK_BIT      = 8,
   parameter int          RESP_BIT     = 9,
   parameter int          MAX_FAILS    = 3,
   parameter logic [15:0] STAT_GEN_ERR = 16'h00FE,
   parameter logic [15:0] STAT_SEQ_ERR = 16'h00F1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [7:0]       req_class,
   input  logic [7:0]       req_sub,
   input  logic [15:0]      req_flags,
   input  logic [63:0]      req_d1,
   input  logic [63:0]      req_d2,
   input  logic [63:0]      req_d3,
   output logic             cmd_we,
   output logic [63:0]      cmd_w0,
   output logic [63:0]      cmd_w1,
   output logic [63:0]      cmd_w2,
   output logic [63:0]      cmd_w3,
   input  logic             cmd_err,
   output logic             eng_ring,
   input  logic [DB_W-1:0]  host_db,
   output logic             db_and_we,
   output logic [DB_W-1:0]  db_and_val,
   input  logic [63:0]      rsp_hdr,
   input  logic [TMO_W-1:0] tmo_limit,
   output logic             cpl_valid,
   output logic [1:0]       cpl_code,
   output logic [15:0]      cpl_status,
   output logic [15:0]      cpl_seq,
   output logic             pass_pulse,
   output logic             timer_pulse
);
   localparam int ENT_W  = $bits(cmd_ent_t);
   localparam int FAIL_W = $clog2(MAX_FAILS + 1);
   localparam logic [15:0] ACK_MASK = 16'(1) << ACK_BIT;

   generate
      if (ACK_BIT == RESP_BIT || ACK_BIT > 15 || RESP_BIT > 15) begin : g_bad_flags
         $error("mbx_cmd_seq: flag bit positions invalid");
      end
      if (MAX_FAILS < 1) begin : g_bad_fails
         $error("mbx_cmd_seq: MAX_FAILS must be at least 1");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("mbx_cmd_seq: TMO_W must be at least 2");
      end
   endgenerate

   // request queue; the head entry is the in-flight command
   cmd_ent_t         head, in_ent;
   logic [ENT_W-1:0] fifo_dout;
   logic             fifo_full, fifo_empty, push, pop;
   logic [SEQ_W-1:0] seq_now;

   assign req_ready = !fifo_full;
   assign push      = req_valid && !fifo_full;

   mbx_seq_gen #(.SEQ_W(SEQ_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .advance(push), .seq(seq_now)
   );

   always_comb begin
      in_ent.cls   = req_class;
      in_ent.sub   = req_sub;
      in_ent.flags = req_flags;
      in_ent.seq   = 16'(seq_now);
      in_ent.d1    = req_d1;
      in_ent.d2    = req_d2;
      in_ent.d3    = req_d3;
   end

   mbx_cmd_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(ENT_W'(in_ent)),
      .pop(pop), .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
   );
   assign head = cmd_ent_t'(fifo_dout);

   // doorbell cause picker
   db_ev_e          ev;
   logic [DB_W-1:0] pick_val;

   mbx_db_pick #(.DB_W(DB_W)) u_pick (
      .bits(host_db), .ev(ev), .and_val(pick_val)
   );

   // mailbox control state
   mb_state_e         mb_state;
   logic [TMO_W-1:0]  tmo_cnt;
   logic [FAIL_W-1:0] fail_cnt;
   logic              stopped;

   logic busy, svc, tmo_hit, do_tmo, send_now, needs_rsp, seq_ok;
   logic fin_ack, fin_rsp, fin_err, go_wresp, last_fail;
   cpl_code_e   code_n;
   logic [15:0] stat_n;

   assign busy      = (mb_state != MB_IDLE);
   assign svc       = |host_db;
   assign tmo_hit   = busy && (tmo_cnt >= tmo_limit);
   assign do_tmo    = !svc && tmo_hit;
   assign send_now  = !svc && !busy && !fifo_empty && !stopped;
   assign needs_rsp = head.flags[RESP_BIT];
   assign seq_ok    = (rsp_hdr[31:16] == head.seq);
   assign last_fail = (fail_cnt == FAIL_W'(MAX_FAILS - 1));

   assign fin_ack  = svc && (ev == EV_ACK) && (mb_state == MB_SENT) && !needs_rsp;
   assign go_wresp = svc && (ev == EV_ACK) && (mb_state == MB_SENT) && needs_rsp;
   assign fin_rsp  = svc && (ev == EV_RESP) && busy;
   assign fin_err  = send_now && cmd_err;
   assign pop      = fin_ack || fin_rsp || do_tmo || fin_err;

   assign db_and_we  = svc;
   assign db_and_val = pick_val;
   assign cmd_we     = send_now;
   assign eng_ring   = send_now && !cmd_err;
   assign cmd_w0     = {16'h0000, head.flags | ACK_MASK, head.seq, head.cls, head.sub};
   assign cmd_w1     = head.d1;
   assign cmd_w2     = head.d2;
   assign cmd_w3     = head.d3;

   always_comb begin
      code_n = CPL_ERR;
      stat_n = STAT_GEN_ERR;
      if (fin_rsp) begin
         code_n = CPL_DONE;
         stat_n = seq_ok ? rsp_hdr[63:48] : STAT_SEQ_ERR;
      end else if (fin_ack) begin
         code_n = CPL_DONE;
         stat_n = 16'h0000;
      end else if (do_tmo) begin
         code_n = CPL_TMO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mb_state    <= MB_IDLE;
         tmo_cnt     <= '0;
         fail_cnt    <= '0;
         stopped     <= 1'b0;
         cpl_valid   <= 1'b0;
         cpl_code    <= CPL_DONE;
         cpl_status  <= '0;
         cpl_seq     <= '0;
         pass_pulse  <= 1'b0;
         timer_pulse <= 1'b0;
      end else begin
         cpl_valid   <= pop;
         pass_pulse  <= svc && (ev == EV_PASS);
         timer_pulse <= svc && (ev == EV_TIMER);
         if (pop) begin
            cpl_code   <= code_n;
            cpl_status <= stat_n;
            cpl_seq    <= head.seq;
         end

         if ((svc && ev == EV_RESET) || pop) mb_state <= MB_IDLE;
         else if (go_wresp)                  mb_state <= MB_WRESP;
         else if (send_now)                  mb_state <= MB_SENT;

         if (send_now)                    tmo_cnt <= '0;
         else if (busy && tmo_cnt != '1)  tmo_cnt <= tmo_cnt + 1'b1;

         if (svc)                        stopped <= 1'b0;
         else if (fin_err && last_fail)  stopped <= 1'b1;

         if (send_now) begin
            if (!cmd_err)       fail_cnt <= '0;
            else if (last_fail) fail_cnt <= '0;
            else                fail_cnt <= fail_cnt + 1'b1;
         end
      end
   end

   a_r2_ack_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |-> cmd_w0[32 + ACK_BIT]);
   a_r3_seq_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |-> (cmd_w0[31:16] != 16'h0000));
   a_r4_single_ring: assert property (@(posedge clk) disable iff (!rst_n)
      eng_ring |=> !cmd_we);
   a_r7_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (db_and_we && !host_db[DB_RESET]) |-> ($countones(~db_and_val[DB_KNOWN-1:0]) <= 1));
   a_r8_reset_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
      (db_and_we && host_db[DB_RESET]) |-> (db_and_val == '0));
   a_r9_exclusive_events: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpl_valid, pass_pulse, timer_pulse}));
   a_r11_no_early_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_code == CPL_TMO) |-> ($past(tmo_cnt) >= $past(tmo_limit)));
   a_r12_no_ring_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> !eng_ring);

endmodule

// File: tb/test_mbx_cmd_seq.sv
`timescale 1ns/1ps
module test_mbx_cmd_seq;
   localparam int DB_W = 8;
   localparam int LIM  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        req_valid = 1'b0, cmd_err = 1'b0;
   logic [7:0]  req_class = '0, req_sub = '0;
   logic [15:0] req_flags = '0;
   logic [63:0] req_d1 = '0, req_d2 = '0, req_d3 = '0, rsp_hdr = '0;
   logic [7:0]  tmo_limit = 8'(LIM);
   logic        req_ready, cmd_we, eng_ring, db_and_we, cpl_valid, pass_pulse, timer_pulse;
   logic [63:0] cmd_w0, cmd_w1, cmd_w2, cmd_w3;
   logic [DB_W-1:0] db = '0, db_set = '0, db_and_val;
   logic [1:0]  cpl_code;
   logic [15:0] cpl_status, cpl_seq;

   mbx_cmd_seq #(.DEPTH(4), .SEQ_W(4), .TMO_W(8), .DB_W(DB_W)) i_mbx_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_class(req_class), .req_sub(req_sub), .req_flags(req_flags),
      .req_d1(req_d1), .req_d2(req_d2), .req_d3(req_d3),
      .cmd_we(cmd_we), .cmd_w0(cmd_w0), .cmd_w1(cmd_w1), .cmd_w2(cmd_w2), .cmd_w3(cmd_w3),
      .cmd_err(cmd_err), .eng_ring(eng_ring), .host_db(db), .db_and_we(db_and_we),
      .db_and_val(db_and_val), .rsp_hdr(rsp_hdr), .tmo_limit(tmo_limit),
      .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_status(cpl_status),
      .cpl_seq(cpl_seq), .pass_pulse(pass_pulse), .timer_pulse(timer_pulse)
   );

   // engine-side doorbell register model
   always @(posedge clk) begin
      if (!rst_n) db <= '0;
      else        db <= (db_and_we ? (db & db_and_val) : db) | db_set;
   end

   // monitor, sampling at the falling edge
   int cyc = 0, n_we = 0, n_ring = 0, n_cpl = 0, n_pass = 0, n_tm = 0, n_clr = 0;
   int ring_cyc = 0, cpl_cyc = 0;
   logic [63:0] m_w0, m_w1, m_w2, m_w3;
   logic [1:0]  m_code;
   logic [15:0] m_stat, m_seq;
   logic [DB_W-1:0] clr_log [16];
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (cmd_we) n_we++;
      if (eng_ring) begin
         n_ring++; ring_cyc = cyc;
         m_w0 = cmd_w0; m_w1 = cmd_w1; m_w2 = cmd_w2; m_w3 = cmd_w3;
      end
      if (cpl_valid) begin
         n_cpl++; cpl_cyc = cyc;
         m_code = cpl_code; m_stat = cpl_status; m_seq = cpl_seq;
      end
      if (pass_pulse) n_pass++;
      if (timer_pulse) n_tm++;
      if (db_and_we) begin clr_log[n_clr % 16] = db_and_val; n_clr++; end
   end

   int nchk = 0, nerr = 0, npush = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #2;
   endtask

   function automatic logic [15:0] exp_seq(input int k);
      return 16'(((k - 1) % 14) + 1);
   endfunction

   task automatic push(input logic [7:0] c, input logic [7:0] s, input logic [15:0] f);
      npush++;
      req_class = c; req_sub = s; req_flags = f;
      req_d1 = 64'hD100_0000_0000_0000 | 64'(npush);
      req_d2 = 64'hD200_0000_0000_0000 | 64'(npush);
      req_d3 = 64'hD300_0000_0000_0000 | 64'(npush);
      req_valid = 1'b1;
      while (!req_ready) tick();
      tick();
      req_valid = 1'b0;
   endtask

   task automatic check_words(input string req, input int k, input logic [7:0] c,
                              input logic [7:0] s, input logic [15:0] f);
      chk(req, m_w0, {16'h0000, f | 16'h0100, exp_seq(k), c, s});
      chk(req, m_w1, 64'hD100_0000_0000_0000 | 64'(k));
      chk(req, m_w3, 64'hD300_0000_0000_0000 | 64'(k));
   endtask

   task automatic wait_ring(input int prev);
      int n = 0;
      while (n_ring <= prev && n < 200) begin tick(); n++; end
      chk("R4 ring seen", 64'(n_ring > prev), 64'd1);
   endtask

   task automatic wait_cpl(input int prev);
      int n = 0;
      while (n_cpl <= prev && n < 200) begin tick(); n++; end
      chk("R5 completion seen", 64'(n_cpl > prev), 64'd1);
   endtask

   task automatic ring_db(input logic [DB_W-1:0] b);
      db_set = b; tick(); db_set = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      int r, c, nc, np, nt, we0;
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      chk("R14 ready after reset", 64'(req_ready), 64'd1);
      chk("R4 no write after reset", 64'(cmd_we), 64'd0);
      chk("R5 no completion after reset", 64'(cpl_valid), 64'd0);
      chk("R7 no clear after reset", 64'(db_and_we), 64'd0);

      // A: plain command, completes on acknowledge
      r = n_ring; c = n_cpl;
      push(8'h12, 8'h34, 16'h0000);
      wait_ring(r);
      check_words("R1 header A", 1, 8'h12, 8'h34, 16'h0000);
      chk("R2 ack flag", 64'(m_w0[40]), 64'd1);
      ring_db(8'h02);
      wait_cpl(c);
      chk("R5 ack done code", 64'(m_code), 64'd0);
      chk("R5 ack done status", 64'(m_stat), 64'd0);
      chk("R3 first seq", 64'(m_seq), 64'd1);
      tick();
      chk("R7 ack cleared", 64'(db), 64'd0);

      // B, C: response commands, one outstanding
      r = n_ring; c = n_cpl;
      push(8'h21, 8'h01, 16'h0200);
      push(8'h22, 8'h02, 16'h0200);
      wait_ring(r);
      check_words("R2 header B", 2, 8'h21, 8'h01, 16'h0200);
      we0 = n_we;
      repeat (10) tick();
      chk("R4 single outstanding", 64'(n_ring), 64'(r + 1));
      chk("R4 no extra write", 64'(n_we), 64'(we0));
      ring_db(8'h02);
      repeat (5) tick();
      chk("R5 ack waits for response", 64'(n_cpl), 64'(c));
      rsp_hdr = {16'h1234, 16'h0000, 16'd2, 16'h0000};
      ring_db(8'h04);
      wait_cpl(c);
      chk("R6 status match", 64'(m_stat), 64'h1234);
      chk("R6 code", 64'(m_code), 64'd0);
      wait_ring(r + 1);
      check_words("R1 header C", 3, 8'h22, 8'h02, 16'h0200);
      c = n_cpl;
      ring_db(8'h02);
      rsp_hdr = {16'h5555, 16'h0000, 16'd5, 16'h0000};
      ring_db(8'h04);
      wait_cpl(c);
      chk("R6 sequence mismatch", 64'(m_stat), 64'h00F1);

      // D: every cause at once
      r = n_ring; c = n_cpl;
      push(8'h30, 8'h03, 16'h0200);
      wait_ring(r);
      rsp_hdr = {16'h0BEE, 16'h0000, 16'd4, 16'h0000};
      nc = n_clr; np = n_pass; nt = n_tm;
      ring_db(8'b0101_1110);
      wait_cpl(c);
      repeat (8) tick();
      chk("R7 clear count", 64'(n_clr - nc), 64'd5);
      chk("R7 order ack", 64'(clr_log[(nc + 0) % 16]), 64'hFD);
      chk("R7 order resp", 64'(clr_log[(nc + 1) % 16]), 64'hFB);
      chk("R7 order pass", 64'(clr_log[(nc + 2) % 16]), 64'hF7);
      chk("R7 order timer", 64'(clr_log[(nc + 3) % 16]), 64'hEF);
      chk("R10 unknown mask", 64'(clr_log[(nc + 4) % 16]), 64'h1F);
      chk("R10 doorbell empty", 64'(db), 64'd0);
      chk("R6 status under load", 64'(m_stat), 64'h0BEE);
      chk("R9 one pass pulse", 64'(n_pass - np), 64'd1);
      chk("R9 one timer pulse", 64'(n_tm - nt), 64'd1);

      // E: engine reset with acknowledge pending
      r = n_ring; c = n_cpl;
      push(8'h40, 8'h04, 16'h0000);
      wait_ring(r);
      nc = n_clr;
      ring_db(8'h03);
      wait_ring(r + 1);
      chk("R8 clear all", 64'(clr_log[nc % 16]), 64'h00);
      chk("R8 single clear", 64'(n_clr), 64'(nc + 1));
      chk("R8 no completion", 64'(n_cpl), 64'(c));
      check_words("R8 resend same seq", 5, 8'h40, 8'h04, 16'h0000);
      ring_db(8'h02);
      wait_cpl(c);
      chk("R8 resent completes", 64'(m_seq), 64'd5);

      // stray response
      repeat (3) tick();
      c = n_cpl; nc = n_clr;
      ring_db(8'h04);
      repeat (5) tick();
      chk("R13 no completion", 64'(n_cpl), 64'(c));
      chk("R13 cleared", 64'(n_clr), 64'(nc + 1));

      // F: timeout, full queue, then send failures
      r = n_ring; c = n_cpl;
      push(8'h50, 8'h05, 16'h0200);
      wait_ring(r);
      we0 = n_we;
      push(8'h51, 8'h06, 16'h0000);
      push(8'h52, 8'h07, 16'h0000);
      push(8'h53, 8'h08, 16'h0000);
      chk("R14 full", 64'(req_ready), 64'd0);
      cmd_err = 1'b1;
      wait_cpl(c);
      chk("R11 code", 64'(m_code), 64'd2);
      chk("R11 status", 64'(m_stat), 64'h00FE);
      chk("R11 seq", 64'(m_seq), 64'd6);
      chk("R11 delay", 64'(cpl_cyc - ring_cyc), 64'(LIM + 2));
      repeat (10) tick();
      chk("R12 three failures", 64'(n_cpl), 64'(c + 4));
      chk("R12 error code", 64'(m_code), 64'd1);
      chk("R12 error status", 64'(m_stat), 64'h00FE);
      chk("R12 last seq", 64'(m_seq), 64'd9);
      chk("R12 no ring", 64'(n_ring), 64'(r + 1));
      chk("R12 writes", 64'(n_we), 64'(we0 + 3));
      r = n_ring; c = n_cpl;
      push(8'h60, 8'h0A, 16'h0000);
      we0 = n_we;
      repeat (10) tick();
      chk("R12 stopped", 64'(n_we), 64'(we0));
      cmd_err = 1'b0;
      ring_db(8'h80);
      wait_ring(r);
      check_words("R12 restart", 10, 8'h60, 8'h0A, 16'h0000);
      ring_db(8'h02);
      wait_cpl(c);

      // sequence wrap sweep
      for (int i = 0; i < 6; i++) begin
         r = n_ring; c = n_cpl;
         push(8'h70, 8'(i), 16'h0000);
         wait_ring(r);
         chk("R3 wrap sweep", 64'(m_w0[31:16]), 64'(exp_seq(npush)));
         ring_db(8'h02);
         wait_cpl(c);
      end
      chk("R3 wrapped to one", 64'(m_seq), 64'd2);

      repeat (3) tick();
      finish_run();
   end
endmodule